// File: doc/BRIEF.md
# Capture/Compare Timer with Prescaler

This block is a general-purpose timer. A 16-bit up-counter steps once per tick from a programmable power-of-two prescaler. Eight channels sit beside it. Each channel either stamps the counter value into its own register when its input shows a chosen edge, or compares the counter against a stored value and acts on its output pin when they match. Either kind of channel event sets the channel's status flag, which software can poll. A wrap of the counter sets a separate overflow flag.

Software reaches the timer through a small word-wide register port. Every counter and channel value is read or written as one 16-bit word in a single access, so the two halves of a value always belong together. Reads return data one cycle after the address is presented. Status flags are cleared by writing ones, and only while the timer is enabled.

Top module: `cct_timer`

## Requirements
- R1: After reset every register reads zero and all channel outputs are low.
- R2: CTRL (address 0) bit 0 enables the timer and bits 3:1 hold a prescale code p. While enabled, the counter steps by one every 2^p clock cycles, counted from the cycle in which the enable took effect. While disabled, the counter holds its value.
- R3: When the counter steps from 0xFFFF to 0x0000, FLAGS (address 5) bit 8 is set.
- R4: A write to COUNT (address 1) loads all 16 bits and takes priority over a step in the same cycle. A read of COUNT returns one whole counter value, registered one cycle after the address.
- R5: When MODE (address 2) bit n is 0, channel n captures. A channel input passes a two-flop synchronizer. On the edge chosen by EDGE (address 3) bits 2n+1:2n (1 rising, 2 falling, 3 either), the channel register at address 8+n loads the counter value and FLAGS bit n is set.
- R6: When MODE bit n is 1, channel n compares. On a prescaler tick while the counter equals the channel register, FLAGS bit n is set. At the same edge, ch_out[n] follows ACTION (address 4) bits 2n+1:2n: 0 leaves it, 1 toggles it, 2 drives it low, 3 drives it high.
- R7: Writing ones to FLAGS clears the matching flags only while the enable bit is set. With the enable clear, such a write leaves the flags unchanged.
- R8: When a channel event and a clear of that channel's flag fall in the same cycle, the flag ends up set.
- R9: An edge that the channel's EDGE code does not select, including any edge under code 0, leaves both the channel register and its flag unchanged.
- R10: The configuration registers CTRL, MODE, EDGE and ACTION read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one cycle after the address |
| ch_in | input | 8 | Capture inputs, asynchronous |
| ch_out | output | 8 | Compare outputs, registered |

## Verification
A channel event that sets a flag can land in the same cycle as a software write clearing that flag. The bench provokes this by raising a capture input exactly two falling clock edges before the write to FLAGS. Because the input passes the synchronizer and the edge detector, the capture then lands on the same rising edge as the clear. The flag must read back as set. A separate clear with no event pending must clear it. The bench also collides a counter write with a running prescaler tick and expects the written value, not the incremented one.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int A_CTRL    = 0;
  localparam int A_COUNT   = 1;
  localparam int A_MODE    = 2;
  localparam int A_EDGE    = 3;
  localparam int A_ACTION  = 4;
  localparam int A_FLAGS   = 5;
  localparam int A_CH_BASE = 8;

  typedef enum logic [1:0] {EDG_OFF, EDG_RISE, EDG_FALL, EDG_BOTH} edge_e;
  typedef enum logic [1:0] {ACT_KEEP, ACT_TOGGLE, ACT_LOW, ACT_HIGH} act_e;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(ps));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  assign tick = en && ((div_q & mask) == mask);
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_raw,
  input  logic             cmp_mode,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       action,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] value,
  output logic             evt,
  output logic             pin
);
  import cct_pkg::*;

  logic s1_q, s2_q, s3_q;
  logic rise, fall, cap_hit, cmp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= in_raw;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise    = s2_q && !s3_q;
  assign fall    = !s2_q && s3_q;
  assign cap_hit = !cmp_mode && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
  assign cmp_hit = cmp_mode && tick && (cnt == value);
  assign evt     = cap_hit || cmp_hit;

  always_ff @(posedge clk) begin
    if (rst)          value <= '0;
    else if (cap_hit) value <= cnt;
    else if (wr_en)   value <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else if (cmp_hit) begin
      case (act_e'(action))
        ACT_TOGGLE: pin <= !pin;
        ACT_LOW:    pin <= 1'b0;
        ACT_HIGH:   pin <= 1'b1;
        default:    pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer #(
  parameter int N_CH   = 8,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_CH-1:0]   ch_in,
  output logic [N_CH-1:0]   ch_out
);
  import cct_pkg::*;

  localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(A_COUNT);
  localparam logic [ADDR_W-1:0] AD_MODE  = ADDR_W'(A_MODE);
  localparam logic [ADDR_W-1:0] AD_EDGE  = ADDR_W'(A_EDGE);
  localparam logic [ADDR_W-1:0] AD_ACT   = ADDR_W'(A_ACTION);
  localparam logic [ADDR_W-1:0] AD_FLAGS = ADDR_W'(A_FLAGS);
  localparam int SEL_W = 2 * N_CH;

  logic              en_q;
  logic [PS_W-1:0]   ps_q;
  logic [N_CH-1:0]   mode_q;
  logic [SEL_W-1:0]  edge_q;
  logic [SEL_W-1:0]  act_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [N_CH-1:0]   flag_q;
  logic              ovf_q;
  logic              tick;
  logic              cnt_wr;
  logic              wrap;
  logic [CNT_W-1:0]  clr_mask;
  logic [N_CH-1:0]   ch_evt;
  logic [N_CH-1:0]   ch_wr;
  logic [CNT_W-1:0]  ch_val [N_CH];
  logic [CNT_W-1:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ps_q   <= '0;
      mode_q <= '0;
      edge_q <= '0;
      act_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        AD_CTRL: begin
          en_q <= bus_wdata[0];
          ps_q <= bus_wdata[PS_W:1];
        end
        AD_MODE: mode_q <= bus_wdata[N_CH-1:0];
        AD_EDGE: edge_q <= bus_wdata[SEL_W-1:0];
        AD_ACT:  act_q  <= bus_wdata[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  cct_prescaler #(.PS_W(PS_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .en   (en_q),
    .ps   (ps_q),
    .tick (tick)
  );

  assign cnt_wr = bus_wr && (bus_addr == AD_COUNT);
  assign wrap   = tick && !cnt_wr && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_wr) cnt_q <= bus_wdata;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign clr_mask = (bus_wr && (bus_addr == AD_FLAGS) && en_q) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_mask[N_CH-1:0]) | ch_evt;
      ovf_q  <= (ovf_q & ~clr_mask[N_CH]) | wrap;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_wr[g] = bus_wr && (bus_addr == ADDR_W'(A_CH_BASE + g));

    cct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .in_raw   (ch_in[g]),
      .cmp_mode (mode_q[g]),
      .edge_sel (edge_q[2*g+1:2*g]),
      .action   (act_q[2*g+1:2*g]),
      .cnt      (cnt_q),
      .tick     (tick),
      .wr_en    (ch_wr[g]),
      .wr_data  (bus_wdata),
      .value    (ch_val[g]),
      .evt      (ch_evt[g]),
      .pin      (ch_out[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AD_CTRL:  rd_mux = CNT_W'({ps_q, en_q});
      AD_COUNT: rd_mux = cnt_q;
      AD_MODE:  rd_mux = CNT_W'(mode_q);
      AD_EDGE:  rd_mux = CNT_W'(edge_q);
      AD_ACT:   rd_mux = CNT_W'(act_q);
      AD_FLAGS: rd_mux = CNT_W'({ovf_q, flag_q});
      default: begin
        for (int i = 0; i < N_CH; i++)
          if (bus_addr == ADDR_W'(A_CH_BASE + i)) rd_mux = ch_val[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
  parameter int N_CH   = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              tick,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf,
  input logic [N_CH-1:0]   flags,
  input logic [N_CH-1:0]   ch_evt,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  rdata,
  input logic [N_CH-1:0]   ch_out
);
  import cct_pkg::*;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_wr) |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && (cnt == {CNT_W{1'b1}})) |=> ovf);

  p_rd_count_r4: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_COUNT)) |=> (rdata == $past(cnt)));

  p_keep_flags_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((flags & $past(flags)) == $past(flags)));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (|ch_evt) |=> ((flags & $past(ch_evt)) == $past(ch_evt)));

  p_pin_on_event_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ch_out) |-> ((($past(ch_evt) ^ {N_CH{1'b1}}) & ($past(ch_out) ^ ch_out)) == '0));
endmodule

bind cct_timer cct_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en_q),
  .tick   (tick),
  .cnt_wr (cnt_wr),
  .cnt    (cnt_q),
  .ovf    (ovf_q),
  .flags  (flag_q),
  .ch_evt (ch_evt),
  .addr   (bus_addr),
  .rdata  (bus_rdata),
  .ch_out (ch_out)
);

// File: tb/cct_timer_tb.sv
module cct_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  ch_in = '0;
  logic [7:0]  ch_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] pin_m = '0;

  always #4 clk = ~clk;

  cct_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_in(ch_in), .ch_out(ch_out)
  );

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic exp_pin(input logic old, input int act);
    case (act)
      1: return !old;
      2: return 1'b0;
      3: return 1'b1;
      default: return old;
    endcase
  endfunction

  function automatic logic [15:0] exp_cnt(input int cycles, input int ps);
    return 16'(cycles >> ps);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d, f0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 count", d, 0);
    rd(5, d); chk("R1 flags", d, 0);
    rd(9, d); chk("R1 channel reg", d, 0);
    chk("R1 ch_out", ch_out, 0);

    // R10 readback
    wr(2, 16'h00A5); rd(2, d); chk("R10 mode", d, 16'h00A5);
    wr(3, 16'hC3C3); rd(3, d); chk("R10 edge", d, 16'hC3C3);
    wr(4, 16'h1E2D); rd(4, d); chk("R10 action", d, 16'h1E2D);
    wr(0, 16'h000E); rd(0, d); chk("R10 ctrl", d, 16'h000E);

    // R4 coherent load/read while stopped
    wr(0, 0); wr(1, 16'hBEEF); rd(1, d); chk("R4 count load", d, 16'hBEEF);

    // R5 / R9 capture with frozen counter
    wr(4, 0); wr(2, 0);
    wr(3, 16'((1 << 6) | (3 << 10)));
    wr(1, 16'h1234);
    ch_in[3] = 1'b1; ch_in[6] = 1'b1;
    repeat (5) @(negedge clk);
    rd(11, d); chk("R5 rise capture", d, 16'h1234);
    rd(5, d);  chk("R5 flag3 set", d[3], 1'b1);
    chk("R9 edge off flag6", d[6], 1'b0);
    rd(14, d); chk("R9 edge off reg6", d, 0);
    wr(1, 16'h2222);
    ch_in[3] = 1'b0; ch_in[5] = 1'b1;
    repeat (5) @(negedge clk);
    rd(11, d); chk("R9 falling ignored", d, 16'h1234);
    rd(13, d); chk("R5 both rise", d, 16'h2222);
    wr(1, 16'h3333);
    ch_in[5] = 1'b0;
    repeat (5) @(negedge clk);
    rd(13, d); chk("R5 both fall", d, 16'h3333);

    // R3 overflow
    wr(1, 16'hFFFE); wr(0, 1);
    repeat (2) @(negedge clk);
    wr(0, 0);
    rd(1, d); chk("R3 count after wrap", d, 16'h0001);
    rd(5, f0); chk("R3 ovf flag", f0[8], 1'b1);

    // R7 clear gated by enable
    wr(5, 16'hFFFF); rd(5, d); chk("R7 no clear when disabled", d, f0);
    wr(0, 16'h000F); wr(5, 16'hFFFF); rd(5, d); chk("R7 clear when enabled", d, 0);

    // R8 capture and clear in the same cycle
    ch_in[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(5, 16'h0008);
    rd(5, d); chk("R8 set wins", d[3], 1'b1);
    wr(5, 16'h0008); rd(5, d); chk("R7 plain clear", d[3], 1'b0);

    // R4 write beats tick
    wr(0, 1); wr(1, 16'h00FF); rd(1, d); chk("R4 write priority", d, 16'h00FF);
    wr(0, 0);

    // R6 directed, prescale 1, drive high at count 5
    wr(2, 16'h0001); wr(4, 16'h0003); wr(8, 16'd5); wr(3, 0); wr(1, 0);
    wr(0, 1);
    repeat (5) @(negedge clk);
    chk("R6 pin before match", ch_out[0], 1'b0);
    @(negedge clk);
    chk("R6 pin at match", ch_out[0], 1'b1);
    pin_m[0] = 1'b1;
    wr(0, 0);

    // R6 / R2 random
    for (int it = 0; it < 12; it++) begin
      int ch, cmp, ps, act, m;
      ch  = $urandom_range(7, 0);
      cmp = $urandom_range(40, 1);
      ps  = $urandom_range(3, 0);
      act = $urandom_range(3, 0);
      m   = (cmp + 2) << ps;
      wr(0, 0); wr(1, 16'hF000);
      wr(2, 16'(1 << ch)); wr(3, 0); wr(4, 16'(act << (2 * ch)));
      wr(4'(8 + ch), 16'(cmp));
      wr(0, 1); wr(5, 16'h01FF); wr(0, 0); wr(1, 0);
      wr(0, 16'((ps << 1) | 1));
      repeat (m) @(negedge clk);
      wr(0, 0);
      pin_m[ch] = exp_pin(pin_m[ch], act);
      chk("R6 random pins", ch_out, pin_m);
      rd(5, d); chk("R6 random flag", d, 16'(1 << ch));
      rd(1, d); chk("R2 prescaled count", d, exp_cnt(m + 1, ps));
    end

    finish_run();
  end
endmodule